// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block is a behavioural model of one logic cell of a small programmable logic array. A global bus of input signals feeds five product terms. Each term is the AND of bus bits chosen in true or complemented form by mask inputs. A configurable number of those terms, together with an optional sum chained in from a neighbouring cell, are ORed into the cell's sum. That sum is passed on to the next cell, so chained cells build wide sums. A separate foldback term returns a NAND of its own selected literals for other cells to use.

The sum drives a storage element. It can work as a D register, a T register or a transparent latch. Its clock or enable comes from a global pin or from a product term. An asynchronous clear comes from a global reset pin or from a product term, a product-term preset can be enabled, and a global clear always acts. The pad output carries either the stored value or the raw sum. The output enable comes from a global pin or a product term. The stored value always returns on a buried feedback, and the pad's input value returns on its own feedback line. The mode selections, the term count and the cascade enable are captured only while the synchronous reset `rst` is high.

The selected clock source is sampled on the system clock `clk`. A register event happens at the first system edge that sees the source high after it was seen low.

Top module: `cpld_macrocell`

## Requirements
- R1: Product term t is the AND, over every bus bit i, of `bus_in[i]` where true-mask bit t*NUM_IN+i is 1 and of `~bus_in[i]` where complement-mask bit t*NUM_IN+i is 1. A term with no mask bit set is 1.
- R2: `cascade_out` is the OR of terms 0 to `cfg_pt_used`-1. A count of 0 gives an empty sum, and counts above 5 take all five terms.
- R3: With `cfg_casc_en` = 1, `cascade_in` is ORed into the sum. With 0 it has no effect.
- R4: `foldback_out` is the NAND of the literals that the foldback masks select, using the same masking rule as R1.
- R5: With `cfg_mode` = 0 (D), the register takes the sum at each rise of the clock source. The new value shows on `fb_reg` after the first `clk` edge that sees the rise. Without a rise the value holds.
- R6: With `cfg_mode` = 1 (T), the register inverts at a clock-source rise only when the sum is 1.
- R7: With `cfg_mode` = 2 (latch), `fb_reg` follows the sum in the same cycle while the clock source is high. It holds the last value passed while the source is low.
- R8: With `cfg_clk_pt` = 0 the clock source is `gclk_pin`. With 1 it is product term 4, and `gclk_pin` then has no effect.
- R9: `gclr`, and either `grst_pin` (`cfg_rst_pt` = 0) or product term 3 (`cfg_rst_pt` = 1), clear `fb_reg` to 0 at once. The value stays 0 after release until the next event.
- R10: With `cfg_pre_en` = 1, product term 1 sets `fb_reg` to 1 at once. When preset and clear are both active, the clear wins.
- R11: `pad_oe` follows `goe_pin` (`cfg_oe_pt` = 0) or product term 2 (`cfg_oe_pt` = 1). `fb_pin` always shows `pad_in`, including while `pad_oe` is 0.
- R12: With `cfg_comb_out` = 1, `pad_out` is the sum while `fb_reg` still carries the stored value. With 0, `pad_out` carries the stored value.
- R13: Configuration inputs are captured only while `rst` is high. Changes made while `rst` is low have no effect.
- R14: Reset leaves `fb_reg` at 0. A clock source that is already high when reset releases causes no event until it has been seen low and then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; captures configuration |
| bus_in | input | NUM_IN | Global bus signals |
| pt_true_mask | input | 5*NUM_IN | True-literal select, term t at bits t*NUM_IN+i |
| pt_comp_mask | input | 5*NUM_IN | Complement-literal select, same layout |
| fb_true_mask | input | NUM_IN | Foldback true-literal select |
| fb_comp_mask | input | NUM_IN | Foldback complement-literal select |
| cascade_in | input | 1 | Sum chained in from the neighbouring cell |
| cfg_pt_used | input | 3 | Number of terms in the OR sum |
| cfg_casc_en | input | 1 | Admit cascade_in into the sum |
| cfg_mode | input | 2 | 0 D, 1 T, 2 latch, 3 behaves as D |
| cfg_clk_pt | input | 1 | Clock source: 0 gclk_pin, 1 term 4 |
| cfg_rst_pt | input | 1 | Clear source: 0 grst_pin, 1 term 3 |
| cfg_oe_pt | input | 1 | Enable source: 0 goe_pin, 1 term 2 |
| cfg_pre_en | input | 1 | Let term 1 preset the register |
| cfg_comb_out | input | 1 | Pad carries the sum instead of the register |
| gclk_pin | input | 1 | Global clock pin |
| grst_pin | input | 1 | Global reset pin |
| goe_pin | input | 1 | Global output-enable pin |
| gclr | input | 1 | Global clear |
| pad_in | input | 1 | Value seen on the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable; 0 releases the pad |
| fb_reg | output | 1 | Buried feedback of the stored value |
| fb_pin | output | 1 | Input feedback from the pad |
| cascade_out | output | 1 | Sum passed to the next cell |
| foldback_out | output | 1 | Foldback NAND term |

## Verification
The assertions take for granted that configuration only changes while `rst` is high. They also assume that each level of the clock source lasts at least one system clock, so every rise of the source is seen by the sampling stage and tied to exactly one event. The bench drives every input at the falling edge of `clk` and holds each clock-source level for at least a full cycle. It also changes configuration only inside its reset-loading task, except in the one test that changes it outside reset on purpose to show it is ignored. For latch mode it keeps the sum steady at the moment the enable falls, so the held value is well defined.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int PT_NUM   = 5;
    localparam int PT_CNT_W = $clog2(PT_NUM + 1);
    localparam int PT_PRE   = 1;
    localparam int PT_OE    = 2;
    localparam int PT_RST   = 3;
    localparam int PT_CLK   = 4;

    typedef enum logic [1:0] {
        SM_DFF   = 2'd0,
        SM_TFF   = 2'd1,
        SM_LATCH = 2'd2,
        SM_RSVD  = 2'd3
    } store_mode_e;

    typedef struct packed {
        store_mode_e         mode;
        logic                clk_pt;
        logic                rst_pt;
        logic                oe_pt;
        logic                pre_en;
        logic                casc_en;
        logic                comb_out;
        logic [PT_CNT_W-1:0] pt_used;
    } mc_cfg_t;

    typedef struct packed {
        logic clr;
        logic pre;
    } async_t;

    function automatic logic term_in_sum(input logic [PT_CNT_W-1:0] used, input int idx);
        return logic'(int'(used) > idx);
    endfunction
endpackage

// File: rtl/mc_and_array.sv
module mc_and_array #(
    parameter int NUM_IN = 8,
    parameter int TERMS  = 5
) (
    input  logic [NUM_IN-1:0]       bus_in,
    input  logic [TERMS*NUM_IN-1:0] t_mask,
    input  logic [TERMS*NUM_IN-1:0] c_mask,
    output logic [TERMS-1:0]        terms
);
    for (genvar t = 0; t < TERMS; t++) begin : g_term
        logic [NUM_IN-1:0] tm, cm;
        assign tm = t_mask[t*NUM_IN +: NUM_IN];
        assign cm = c_mask[t*NUM_IN +: NUM_IN];
        // a literal passes when unselected, or when it matches its polarity
        assign terms[t] = &((~tm | bus_in) & (~cm | ~bus_in));
    end
endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  store_mode_e mode,
    input  logic        csrc,
    input  logic        d,
    input  async_t      asy,
    output logic        q,
    output logic        edge_o
);
    logic q_reg, prev_src, q_nxt;

    assign edge_o = csrc & ~prev_src;

    always_comb begin
        if (asy.clr)                        q = 1'b0;
        else if (asy.pre)                   q = 1'b1;
        else if (mode == SM_LATCH && csrc)  q = d;
        else                                q = q_reg;
    end

    always_comb begin
        unique case (mode)
            SM_TFF:   q_nxt = edge_o ? (q_reg ^ d) : q_reg;
            SM_LATCH: q_nxt = csrc ? d : q_reg;
            default:  q_nxt = edge_o ? d : q_reg;
        endcase
        if (asy.clr)      q_nxt = 1'b0;
        else if (asy.pre) q_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_reg    <= 1'b0;
            prev_src <= 1'b1;   // a source already high at release is not an edge
        end else begin
            q_reg    <= q_nxt;
            prev_src <= csrc;
        end
    end
endmodule

// File: rtl/cpld_macrocell.sv
module cpld_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_IN-1:0]        bus_in,
    input  logic [PT_NUM*NUM_IN-1:0] pt_true_mask,
    input  logic [PT_NUM*NUM_IN-1:0] pt_comp_mask,
    input  logic [NUM_IN-1:0]        fb_true_mask,
    input  logic [NUM_IN-1:0]        fb_comp_mask,
    input  logic                     cascade_in,
    input  logic [PT_CNT_W-1:0]      cfg_pt_used,
    input  logic                     cfg_casc_en,
    input  logic [1:0]               cfg_mode,
    input  logic                     cfg_clk_pt,
    input  logic                     cfg_rst_pt,
    input  logic                     cfg_oe_pt,
    input  logic                     cfg_pre_en,
    input  logic                     cfg_comb_out,
    input  logic                     gclk_pin,
    input  logic                     grst_pin,
    input  logic                     goe_pin,
    input  logic                     gclr,
    input  logic                     pad_in,
    output logic                     pad_out,
    output logic                     pad_oe,
    output logic                     fb_reg,
    output logic                     fb_pin,
    output logic                     cascade_out,
    output logic                     foldback_out
);
    mc_cfg_t             cfg_q;
    logic [PT_NUM-1:0]   pt;
    logic                fb_term;
    logic                own_sum, pt_sum, csrc, edge_p;
    async_t              asy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode     <= store_mode_e'(cfg_mode);
            cfg_q.clk_pt   <= cfg_clk_pt;
            cfg_q.rst_pt   <= cfg_rst_pt;
            cfg_q.oe_pt    <= cfg_oe_pt;
            cfg_q.pre_en   <= cfg_pre_en;
            cfg_q.casc_en  <= cfg_casc_en;
            cfg_q.comb_out <= cfg_comb_out;
            cfg_q.pt_used  <= cfg_pt_used;
        end
    end

    mc_and_array #(.NUM_IN(NUM_IN), .TERMS(PT_NUM)) u_terms (
        .bus_in (bus_in),
        .t_mask (pt_true_mask),
        .c_mask (pt_comp_mask),
        .terms  (pt)
    );

    mc_and_array #(.NUM_IN(NUM_IN), .TERMS(1)) u_fold (
        .bus_in (bus_in),
        .t_mask (fb_true_mask),
        .c_mask (fb_comp_mask),
        .terms  (fb_term)
    );

    always_comb begin
        own_sum = 1'b0;
        for (int t = 0; t < PT_NUM; t++)
            own_sum = own_sum | (pt[t] & term_in_sum(cfg_q.pt_used, t));
    end

    assign pt_sum  = own_sum | (cfg_q.casc_en & cascade_in);
    assign csrc    = cfg_q.clk_pt ? pt[PT_CLK] : gclk_pin;
    assign asy.clr = gclr | (cfg_q.rst_pt ? pt[PT_RST] : grst_pin);
    assign asy.pre = cfg_q.pre_en & pt[PT_PRE];

    mc_store u_store (
        .clk    (clk),
        .rst    (rst),
        .mode   (cfg_q.mode),
        .csrc   (csrc),
        .d      (pt_sum),
        .asy    (asy),
        .q      (fb_reg),
        .edge_o (edge_p)
    );

    assign cascade_out  = pt_sum;
    assign foldback_out = ~fb_term;
    assign pad_out      = cfg_q.comb_out ? pt_sum : fb_reg;
    assign pad_oe       = cfg_q.oe_pt ? pt[PT_OE] : goe_pin;
    assign fb_pin       = pad_in;
endmodule

// File: rtl/mc_checker.sv
module mc_checker
    import mc_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input mc_cfg_t cfg,
    input logic    fb_reg,
    input logic    pt_sum,
    input logic    edge_p,
    input logic    clr_act,
    input logic    pre_act
);
    // R13: configuration frozen once reset is low
    a_r13_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg));

    // R9: an active clear drives the feedback low
    a_r9_clear_forces_zero: assert property (@(posedge clk) disable iff (rst)
        clr_act |-> !fb_reg);

    // R10: clear beats preset
    a_r10_clear_beats_preset: assert property (@(posedge clk) disable iff (rst)
        (clr_act && pre_act) |-> !fb_reg);

    // R5: edge-triggered modes hold without an event
    a_r5_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && cfg.mode != SM_LATCH && !clr_act && !pre_act
         && !$past(clr_act) && !$past(pre_act) && !$past(edge_p))
        |-> fb_reg == $past(fb_reg));

    // R6: T mode inverts on an event with the sum high
    a_r6_toggle_on_edge: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && cfg.mode == SM_TFF && $past(edge_p) && $past(pt_sum)
         && !clr_act && !pre_act && !$past(clr_act) && !$past(pre_act))
        |-> fb_reg != $past(fb_reg));
endmodule

bind cpld_macrocell mc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg_q),
    .fb_reg  (fb_reg),
    .pt_sum  (pt_sum),
    .edge_p  (edge_p),
    .clr_act (asy.clr),
    .pre_act (asy.pre)
);

// File: tb/sim_cpld_macrocell.sv
module sim_cpld_macrocell;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 8;
    localparam int NT = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NI-1:0] bus_in = '0;
    logic [NT*NI-1:0] pt_true_mask, pt_comp_mask;
    logic [NI-1:0] fb_true_mask, fb_comp_mask;
    logic cascade_in = 1'b0;
    logic [2:0] cfg_pt_used;
    logic cfg_casc_en, cfg_clk_pt, cfg_rst_pt, cfg_oe_pt, cfg_pre_en, cfg_comb_out;
    logic [1:0] cfg_mode;
    logic gclk_pin = 1'b0, grst_pin = 1'b0, goe_pin = 1'b0, gclr = 1'b0, pad_in = 1'b0;
    logic pad_out, pad_oe, fb_reg, fb_pin, cascade_out, foldback_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpld_macrocell #(.NUM_IN(NI)) u0 (
        .clk(clk), .rst(rst), .bus_in(bus_in),
        .pt_true_mask(pt_true_mask), .pt_comp_mask(pt_comp_mask),
        .fb_true_mask(fb_true_mask), .fb_comp_mask(fb_comp_mask),
        .cascade_in(cascade_in), .cfg_pt_used(cfg_pt_used), .cfg_casc_en(cfg_casc_en),
        .cfg_mode(cfg_mode), .cfg_clk_pt(cfg_clk_pt), .cfg_rst_pt(cfg_rst_pt),
        .cfg_oe_pt(cfg_oe_pt), .cfg_pre_en(cfg_pre_en), .cfg_comb_out(cfg_comb_out),
        .gclk_pin(gclk_pin), .grst_pin(grst_pin), .goe_pin(goe_pin), .gclr(gclr),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .fb_reg(fb_reg),
        .fb_pin(fb_pin), .cascade_out(cascade_out), .foldback_out(foldback_out)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic defaults();
        // term k selects bus bit k in true form
        pt_true_mask = '0;
        pt_comp_mask = '0;
        for (int t = 0; t < NT; t++) pt_true_mask[t*NI + t] = 1'b1;
        fb_true_mask = 8'h04;
        fb_comp_mask = 8'h08;
        cfg_pt_used = 3'd1; cfg_casc_en = 1'b0; cfg_mode = 2'd0;
        cfg_clk_pt = 1'b0; cfg_rst_pt = 1'b0; cfg_oe_pt = 1'b0;
        cfg_pre_en = 1'b0; cfg_comb_out = 1'b0;
    endtask

    task automatic load_cfg();
        step();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic pulse_clk();
        gclk_pin = 1'b1; step();
        gclk_pin = 1'b0; step();
    endtask

    task automatic t_reset_state();
        defaults(); load_cfg(); #1;
        check("R14", "fb_reg after reset", fb_reg, 1'b0);
        check("R12", "pad_out after reset", pad_out, 1'b0);
        check("R11", "pad_oe after reset", pad_oe, 1'b0);
    endtask

    task automatic t_terms();
        defaults(); load_cfg();
        pt_true_mask[NI-1:0] = 8'h01; pt_comp_mask[NI-1:0] = 8'h02;
        bus_in = 8'h01; #1 check("R1", "b0 & ~b1 with 01", cascade_out, 1'b1);
        bus_in = 8'h03; #1 check("R1", "b0 & ~b1 with 03", cascade_out, 1'b0);
        bus_in = 8'h00; #1 check("R1", "b0 & ~b1 with 00", cascade_out, 1'b0);
        pt_true_mask[NI-1:0] = 8'h00; pt_comp_mask[NI-1:0] = 8'h00;
        #1 check("R1", "empty term is 1", cascade_out, 1'b1);
        defaults(); bus_in = 8'h00;
    endtask

    task automatic t_term_count();
        defaults(); cfg_pt_used = 3'd2; load_cfg();
        bus_in = 8'h04; #1 check("R2", "term2 outside count 2", cascade_out, 1'b0);
        bus_in = 8'h02; #1 check("R2", "term1 inside count 2", cascade_out, 1'b1);
        cfg_pt_used = 3'd7; load_cfg();
        bus_in = 8'h10; #1 check("R2", "count 7 takes term4", cascade_out, 1'b1);
        cfg_pt_used = 3'd0; load_cfg();
        bus_in = 8'hFF; #1 check("R2", "count 0 empty sum", cascade_out, 1'b0);
        bus_in = 8'h00;
    endtask

    task automatic t_cascade();
        defaults(); cfg_casc_en = 1'b1; load_cfg();
        cascade_in = 1'b1; #1 check("R3", "cascade admitted", cascade_out, 1'b1);
        cascade_in = 1'b0; #1 check("R3", "cascade low", cascade_out, 1'b0);
        cfg_casc_en = 1'b0; load_cfg();
        cascade_in = 1'b1; #1 check("R3", "cascade ignored", cascade_out, 1'b0);
        cascade_in = 1'b0;
    endtask

    task automatic t_foldback();
        bus_in = 8'h04; #1 check("R4", "nand b2&~b3 true", foldback_out, 1'b0);
        bus_in = 8'h00; #1 check("R4", "nand with b2 low", foldback_out, 1'b1);
        bus_in = 8'h0C; #1 check("R4", "nand with b3 high", foldback_out, 1'b1);
        bus_in = 8'h00;
    endtask

    task automatic t_dff();
        defaults(); gclk_pin = 1'b0; bus_in = 8'h00; load_cfg(); step();
        bus_in = 8'h01; gclk_pin = 1'b1;
        #1 check("R5", "before sampling edge", fb_reg, 1'b0);
        step(); check("R5", "captured 1", fb_reg, 1'b1);
        bus_in = 8'h00; step(); check("R5", "no rise holds", fb_reg, 1'b1);
        gclk_pin = 1'b0; step(); gclk_pin = 1'b1; step();
        check("R5", "captured 0", fb_reg, 1'b0);
        gclk_pin = 1'b0;
    endtask

    task automatic t_clock_high_at_release();
        defaults(); gclk_pin = 1'b1; load_cfg();
        bus_in = 8'h01; step(); step();
        check("R14", "high source at release no event", fb_reg, 1'b0);
        gclk_pin = 1'b0; step(); gclk_pin = 1'b1; step();
        check("R14", "event after low then high", fb_reg, 1'b1);
        gclk_pin = 1'b0; bus_in = 8'h00;
    endtask

    task automatic t_tff();
        defaults(); cfg_mode = 2'd1; load_cfg(); step();
        bus_in = 8'h00; pulse_clk(); check("R6", "sum 0 no toggle", fb_reg, 1'b0);
        bus_in = 8'h01; pulse_clk(); check("R6", "toggle to 1", fb_reg, 1'b1);
        pulse_clk(); check("R6", "toggle to 0", fb_reg, 1'b0);
        bus_in = 8'h00;
    endtask

    task automatic t_pt_clock();
        defaults(); cfg_clk_pt = 1'b1; load_cfg(); step();
        bus_in = 8'h01; pulse_clk();
        check("R8", "gclk ignored with term clock", fb_reg, 1'b0);
        bus_in = 8'h11; step();
        check("R8", "term4 rise clocks", fb_reg, 1'b1);
        bus_in = 8'h00;
    endtask

    task automatic t_latch();
        defaults(); cfg_mode = 2'd2; gclk_pin = 1'b0; load_cfg();
        bus_in = 8'h01; #1 check("R7", "closed latch holds", fb_reg, 1'b0);
        gclk_pin = 1'b1; #1 check("R7", "open latch passes 1", fb_reg, 1'b1);
        bus_in = 8'h00; #1 check("R7", "open latch passes 0", fb_reg, 1'b0);
        bus_in = 8'h01; step();
        gclk_pin = 1'b0; #1 check("R7", "closed keeps 1", fb_reg, 1'b1);
        bus_in = 8'h00; #1 check("R7", "closed ignores sum", fb_reg, 1'b1);
        step(); check("R7", "closed still 1", fb_reg, 1'b1);
    endtask

    task automatic t_clear();
        defaults(); load_cfg(); step();
        bus_in = 8'h01; pulse_clk();
        grst_pin = 1'b1; #1 check("R9", "reset pin clears at once", fb_reg, 1'b0);
        step(); grst_pin = 1'b0; step();
        check("R9", "stays 0 after release", fb_reg, 1'b0);
        pulse_clk();
        gclr = 1'b1; #1 check("R9", "global clear", fb_reg, 1'b0);
        step(); gclr = 1'b0;
        cfg_rst_pt = 1'b1; load_cfg(); step();
        pulse_clk(); check("R9", "loaded 1 before term clear", fb_reg, 1'b1);
        bus_in = 8'h09; #1 check("R9", "term3 clears", fb_reg, 1'b0);
        step(); bus_in = 8'h01; step();
        check("R9", "held 0 after term clear", fb_reg, 1'b0);
        bus_in = 8'h00;
    endtask

    task automatic t_preset();
        defaults(); cfg_pre_en = 1'b1; load_cfg(); step();
        bus_in = 8'h02; #1 check("R10", "term1 presets", fb_reg, 1'b1);
        step(); bus_in = 8'h00; step();
        check("R10", "held 1 after preset", fb_reg, 1'b1);
        bus_in = 8'h02; grst_pin = 1'b1; #1 check("R10", "clear beats preset", fb_reg, 1'b0);
        grst_pin = 1'b0; gclr = 1'b1; #1 check("R10", "global clear beats preset", fb_reg, 1'b0);
        step(); gclr = 1'b0; bus_in = 8'h00;
    endtask

    task automatic t_oe();
        defaults(); load_cfg();
        goe_pin = 1'b1; #1 check("R11", "pin enable on", pad_oe, 1'b1);
        goe_pin = 1'b0; pad_in = 1'b1;
        #1 check("R11", "pin enable off", pad_oe, 1'b0);
        check("R11", "pad input while released", fb_pin, 1'b1);
        pad_in = 1'b0; #1 check("R11", "pad input low", fb_pin, 1'b0);
        cfg_oe_pt = 1'b1; load_cfg(); goe_pin = 1'b1;
        bus_in = 8'h04; #1 check("R11", "term2 enables", pad_oe, 1'b1);
        bus_in = 8'h00; #1 check("R11", "term2 low, pin ignored", pad_oe, 1'b0);
        goe_pin = 1'b0;
    endtask

    task automatic t_comb_out();
        defaults(); cfg_comb_out = 1'b1; load_cfg(); step();
        bus_in = 8'h01; #1 check("R12", "pad shows sum", pad_out, 1'b1);
        check("R12", "buried keeps register", fb_reg, 1'b0);
        cfg_comb_out = 1'b0; load_cfg(); step();
        #1 check("R12", "pad shows register", pad_out, 1'b0);
        pulse_clk(); check("R12", "pad after capture", pad_out, 1'b1);
        bus_in = 8'h00;
    endtask

    task automatic t_cfg_frozen();
        defaults(); load_cfg(); step();
        gclk_pin = 1'b1; step();
        cfg_mode = 2'd2; cfg_comb_out = 1'b1;
        bus_in = 8'h01; #1 check("R13", "comb select ignored", pad_out, 1'b0);
        step(); check("R13", "latch select ignored", fb_reg, 1'b0);
        gclk_pin = 1'b0; bus_in = 8'h00; defaults();
    endtask

    initial begin
        defaults();
        t_reset_state();
        t_terms();
        t_term_count();
        t_cascade();
        t_foldback();
        t_dff();
        t_clock_high_at_release();
        t_tff();
        t_pt_clock();
        t_latch();
        t_clear();
        t_preset();
        t_oe();
        t_comb_out();
        t_cfg_frozen();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule